// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block models a single 16-bit down-counting channel of a PC-style interval timer. Software programs it through three byte-wide ports: a write-only mode word, a data port for the count, and a control/status byte. The mode word chooses how data-port bytes are sequenced, or it snapshots the running count. The counter decrements once per pulse of a slow base-rate tick enable, so its timing does not depend on the host clock.

Only the interrupt-on-terminal-count behaviour is built. After a count is loaded, each tick taken while the gate bit is set lowers the count by one. When the count passes from one to zero, the channel output goes high and stays high. Software reads that state as bit 5 of the control byte, and it can route the output to a speaker pin. A typical use is a calibration delay: software loads a count, sets the gate, and polls the status bit.

Top module: `pit_channel`

## Requirements
- R1: After reset, ctrl_rdata is 0x00, cnt_out and spk_out are low, the count is 0 (data_rdata 0x00), and the access mode is low-then-high (code 3).
- R2: The mode word is decoded as follows: bits 7:6 are the channel, bits 5:4 are the access mode, bits 3:1 are the operating mode and bit 0 is BCD. The operating-mode and BCD bits are accepted, but counting is always binary interrupt-on-terminal-count.
- R3: A mode word whose channel field differs from CHAN_IDX leaves the output, the status and the byte sequencing unchanged.
- R4: A mode word for this channel with a non-zero access field clears the output and the status bit. It stops counting until a new count is loaded, drops any latched value, and returns both byte sequencers to the low byte.
- R5: Count loading depends on the access code. Code 1 writes the low byte and clears the high byte. Code 2 writes the high byte and clears the low byte. Code 3 takes the low byte first and the high byte on the next write. The new count takes effect only after its final byte, and loading it clears the output.
- R6: Once loaded, the count drops by one on every tick cycle while ctrl bit 0 (gate) is set. The first drop comes on the first tick after the load cycle. With the gate clear, the count holds.
- R7: A drop from 1 to 0 raises cnt_out and ctrl bit 5. Both stay high, while the count keeps wrapping downward, until a new mode word or a new count is loaded.
- R8: The control byte stores bit 0 (gate) and bit 1 (speaker enable). Written bits 7:2 are ignored. The read value is {2'b00, status, 3'b000, speaker enable, gate}.
- R9: spk_out is high exactly when cnt_out and the speaker enable bit are both high.
- R10: A mode word for this channel with access code 0 copies the current count into a holding register. The next two data reads return its low byte and then its high byte, and the live count keeps running. A second latch command before both bytes are read is ignored.
- R11: Without a latched value, data_rdata shows the live count: the low byte under code 1, the high byte under code 2, and under code 3 the low and high bytes alternating on each read, starting with the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base-rate count enable, one cycle per timer tick |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 8 | Mode word |
| data_we | input | 1 | Data port write strobe |
| data_wdata | input | 8 | Count byte |
| data_re | input | 1 | Data port read strobe, advances the read sequence |
| data_rdata | output | 8 | Count byte currently presented |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte |
| ctrl_rdata | output | 8 | Control/status byte |
| cnt_out | output | 1 | Counter output (terminal count reached) |
| spk_out | output | 1 | Gated speaker output |

## Verification
The bench builds the channel with the default CHAN_IDX of 2. Mode words aimed at channel 0 therefore act as foreign words, which exercises the channel filter, while words for channel 2 drive every access code and the latch command. With the short counts the bench loads, expiry, wrap-around past zero and the gate freeze can all be reached within a few cycles. A random phase mixes these operations with ticks that land in the same cycle as a load.

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int CHAN_IDX = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  input  logic       data_we,
  input  logic [7:0] data_wdata,
  input  logic       data_re,
  output logic [7:0] data_rdata,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output logic [7:0] ctrl_rdata,
  output logic       cnt_out,
  output logic       spk_out
);
  localparam logic [1:0] CH = CHAN_IDX[1:0];

  logic [1:0]  acc;
  logic        wr_hi, rd_hi, latched, armed, gate_en, spk_en;
  logic [7:0]  lo_stage;
  logic [15:0] count, hold, load_val;

  wire m_hit     = mode_we && (mode_wdata[7:6] == CH);
  wire do_latch  = m_hit && (mode_wdata[5:4] == 2'd0);
  wire do_prog   = m_hit && (mode_wdata[5:4] != 2'd0);
  wire load_done = data_we && !do_prog && (acc != 2'd3 || wr_hi);

  always_comb begin
    case (acc)
      2'd1:    load_val = {8'h00, data_wdata};
      2'd2:    load_val = {data_wdata, 8'h00};
      default: load_val = {data_wdata, lo_stage};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= 2'd3; wr_hi <= 1'b0; rd_hi <= 1'b0; latched <= 1'b0;
      armed <= 1'b0; cnt_out <= 1'b0; gate_en <= 1'b0; spk_en <= 1'b0;
      lo_stage <= 8'h00; count <= 16'h0000; hold <= 16'h0000;
    end else begin
      if (data_re) begin
        if (latched) begin
          if (rd_hi) begin latched <= 1'b0; rd_hi <= 1'b0; end
          else rd_hi <= 1'b1;
        end else if (acc == 2'd3) rd_hi <= !rd_hi;
      end
      if (ctrl_we) begin
        gate_en <= ctrl_wdata[0];
        spk_en  <= ctrl_wdata[1];
      end
      if (do_latch && !latched) begin
        hold <= count; latched <= 1'b1; rd_hi <= 1'b0;
      end
      if (do_prog) begin
        acc <= mode_wdata[5:4]; wr_hi <= 1'b0; rd_hi <= 1'b0;
        latched <= 1'b0; armed <= 1'b0; cnt_out <= 1'b0;
      end else if (load_done) begin
        count <= load_val; armed <= 1'b1; cnt_out <= 1'b0; wr_hi <= 1'b0;
      end else begin
        if (data_we) begin lo_stage <= data_wdata; wr_hi <= 1'b1; end
        if (armed && gate_en && tick) begin
          count <= count - 16'd1;
          if (count == 16'd1) cnt_out <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (latched)                        data_rdata = rd_hi ? hold[15:8] : hold[7:0];
    else if (acc == 2'd2)               data_rdata = count[15:8];
    else if (acc == 2'd3 && rd_hi)      data_rdata = count[15:8];
    else                                data_rdata = count[7:0];
  end

  assign ctrl_rdata = {2'b00, cnt_out, 3'b000, spk_en, gate_en};
  assign spk_out    = cnt_out & spk_en;

  assert_foreign_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_wdata[7:6] != CH && !data_we) |=> ($stable(acc) && $stable(wr_hi)));
  assert_prog_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_prog |=> (!cnt_out && !armed && !latched && !wr_hi));
  assert_gate_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && !mode_we && !data_we) |=> $stable(count));
  assert_out_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_out && !do_prog && !load_done) |=> cnt_out);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !do_prog) |=> $stable(hold));
endmodule

// File: tb/tb_pit_channel.sv
module tb_pit_channel;
  logic clk = 0, rst_n = 0, tick = 0;
  logic mode_we = 0, data_we = 0, data_re = 0, ctrl_we = 0;
  logic [7:0] mode_wdata = 0, data_wdata = 0, ctrl_wdata = 0;
  logic [7:0] data_rdata, ctrl_rdata;
  logic cnt_out, spk_out;
  int total = 0, bad = 0, wd = 0;

  pit_channel #(.CHAN_IDX(2)) dut (.*);

  always #5 clk = ~clk;

  int m_cnt, m_hold, m_lo, m_acc, m_wrhi, m_rdhi, m_lat, m_armed, m_out, m_gate, m_spk;

  always @(posedge clk) begin : model
    int oc, olat, ordhi, oacc, owrhi, og, macc;
    bit hit;
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_lo = 0; m_acc = 3; m_wrhi = 0; m_rdhi = 0;
      m_lat = 0; m_armed = 0; m_out = 0; m_gate = 0; m_spk = 0;
    end else begin
      oc = m_cnt; olat = m_lat; ordhi = m_rdhi; oacc = m_acc; owrhi = m_wrhi; og = m_gate;
      hit = mode_we && (mode_wdata[7:6] == 2'd2);
      macc = mode_wdata[5:4];
      if (data_re) begin
        if (olat != 0) begin
          if (ordhi != 0) begin m_lat = 0; m_rdhi = 0; end else m_rdhi = 1;
        end else if (oacc == 3) m_rdhi = (ordhi == 0);
      end
      if (ctrl_we) begin m_gate = ctrl_wdata[0]; m_spk = ctrl_wdata[1]; end
      if (hit && macc == 0 && olat == 0) begin m_hold = oc; m_lat = 1; m_rdhi = 0; end
      if (hit && macc != 0) begin
        m_acc = macc; m_wrhi = 0; m_rdhi = 0; m_lat = 0; m_armed = 0; m_out = 0;
      end else if (data_we && (oacc != 3 || owrhi != 0)) begin
        if (oacc == 1) m_cnt = data_wdata;
        else if (oacc == 2) m_cnt = data_wdata * 256;
        else m_cnt = data_wdata * 256 + m_lo;
        m_armed = 1; m_out = 0; m_wrhi = 0;
      end else begin
        if (data_we) begin m_lo = data_wdata; m_wrhi = 1; end
        if (m_armed != 0 && og != 0 && tick) begin
          if (oc == 1) m_out = 1;
          m_cnt = (oc + 65535) % 65536;
        end
      end
    end
  end

  function automatic int exp_rd();
    if (m_lat != 0) return m_rdhi != 0 ? m_hold / 256 : m_hold % 256;
    if (m_acc == 2 || (m_acc == 3 && m_rdhi != 0)) return m_cnt / 256;
    return m_cnt % 256;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R11/R10 data_rdata vs model", data_rdata, exp_rd());
    chk("R8/R7 ctrl_rdata vs model", ctrl_rdata, m_out * 32 + m_spk * 2 + m_gate);
    chk("R7 cnt_out vs model", cnt_out, m_out);
    chk("R9 spk_out vs model", spk_out, m_out & m_spk);
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(); @(negedge clk); #1; endtask
  task automatic mode_w(input logic [7:0] v); mode_wdata = v; mode_we = 1; cyc(); mode_we = 0; endtask
  task automatic data_w(input logic [7:0] v); data_wdata = v; data_we = 1; cyc(); data_we = 0; endtask
  task automatic ctrl_w(input logic [7:0] v); ctrl_wdata = v; ctrl_we = 1; cyc(); ctrl_we = 0; endtask
  task automatic rd(); data_re = 1; cyc(); data_re = 0; endtask
  task automatic ticks(input int n); tick = 1; repeat (n) cyc(); tick = 0; endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    chk("R1 ctrl reset", ctrl_rdata, 8'h00);
    chk("R1 out reset", cnt_out, 0);
    chk("R1 spk reset", spk_out, 0);
    chk("R1 count reset", data_rdata, 8'h00);

    ctrl_w(8'hFE); chk("R8 ignored upper bits", ctrl_rdata, 8'h02);
    ctrl_w(8'hFF); chk("R8 gate+spk", ctrl_rdata, 8'h03);

    mode_w(8'hB0); data_w(8'h05); ticks(2); data_w(8'h00);
    chk("R5 low-high load", data_rdata, 8'h05);
    ticks(4); chk("R6 not yet expired", cnt_out, 0);
    chk("R6 count after 4", data_rdata, 8'h01);
    ticks(1); chk("R7 expiry out", cnt_out, 1);
    chk("R7 status bit", ctrl_rdata, 8'h23);
    chk("R9 speaker on", spk_out, 1);
    ticks(2); chk("R7 sticky", cnt_out, 1);
    chk("R7 wrap low", data_rdata, 8'hFE);
    rd(); chk("R11 alternate high", data_rdata, 8'hFF);
    rd(); chk("R11 back to low", data_rdata, 8'hFE);
    ctrl_w(8'h01); chk("R9 speaker gated off", spk_out, 0);
    mode_w(8'h30); chk("R3 foreign keeps out", cnt_out, 1);
    chk("R3 foreign keeps status", ctrl_rdata, 8'h21);

    mode_w(8'h90); chk("R4 prog clears", ctrl_rdata, 8'h01);
    chk("R4 out cleared", cnt_out, 0);
    data_w(8'h07); chk("R5 low only", data_rdata, 8'h07);
    ctrl_w(8'h00); ticks(3); chk("R6 gate freeze", data_rdata, 8'h07);
    ctrl_w(8'h01); ticks(3); chk("R6 gate run", data_rdata, 8'h04);

    mode_w(8'hA0); data_w(8'h02); chk("R5 high only", data_rdata, 8'h02);
    ticks(1); chk("R11 high byte view", data_rdata, 8'h01);
    mode_w(8'h80); ticks(5);
    chk("R10 latched low", data_rdata, 8'hFF);
    mode_w(8'h80); chk("R10 relatch ignored", data_rdata, 8'hFF);
    rd(); chk("R10 latched high", data_rdata, 8'h01);
    rd(); chk("R10 live after latch", data_rdata, 8'h01);

    mode_w(8'hB0); data_w(8'h34); data_w(8'h12); ticks(2);
    mode_w(8'h80); ticks(3);
    chk("R10 hold low", data_rdata, 8'h32);
    rd(); chk("R10 hold high", data_rdata, 8'h12);
    rd(); chk("R10 live keeps running", data_rdata, 8'h2F);

    mode_w(8'hB7); data_w(8'h03); data_w(8'h00); ticks(3);
    chk("R2 nonzero op/bcd act as mode 0", cnt_out, 1);
    data_w(8'h02); data_w(8'h00); chk("R5 reload clears out", cnt_out, 0);

    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom % 12;
      tick = ($urandom % 2) == 1;
      case (r)
        0: begin mode_wdata = {($urandom % 4 == 0) ? 2'd0 : 2'd2, 6'($urandom)}; mode_we = 1; end
        1, 2, 3: begin data_wdata = 8'($urandom % 6); data_we = 1; end
        4, 5: data_re = 1;
        6: begin ctrl_wdata = 8'($urandom); ctrl_we = 1; end
        default: ;
      endcase
      cyc();
      mode_we = 0; data_we = 0; data_re = 0; ctrl_we = 0;
    end
    tick = 0; cyc();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule